// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the register-side controller for an embedded flash macro. A simple 32-bit register bus (write strobe, byte address, write data, combinational read data) loads a target address, a tick divider, four data words and a control word. A command written into the control word, when accepted, produces exactly one operation on a generic flash port: a 128-bit program, a 32-bit program, a page erase or a whole-array erase.

Each operation raises a one-cycle strobe on the flash port. The port carries the operation code, the address, the data and the width. The block then stays busy for a fixed number of divided ticks before it reports completion. Commands are refused unless a 4-bit key in the control word holds the unlock value. An erase also needs a matching erase code. A refused command sets a sticky access-fault flag. A sticky done flag and the fault flag each have their own interrupt enable, and the two masked flags drive a single interrupt line.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and no flash strobe is issued.
- R2: The register map is fixed as follows. The address register is at 0x00, the divider (bits 7:0) at 0x04, the control word at 0x08, the status register at 0x24 and data words 0 to 3 at 0x30, 0x34, 0x38 and 0x3C. Each of these reads back what was written. The access register at 0x40 always reads 0.
- R3: A program command is control bit 0 set with key field bits 31:28 equal to 2. It issues one strobe with `fl_op_o`=1 and the address register value on `fl_addr_o`. Control bit 0 reads 1 while the program runs and 0 once it is done.
- R4: Control bit 4 selects the program width. When it is 0, `fl_wide_o`=1 and data words 0 to 3 are written to four consecutive words of an aligned 16-byte group. When it is 1, `fl_wide_o`=0 and only data word 0 is written, at the addressed word. `fl_data_o` carries word 0 in bits 31:0 and word k in bits 32k+31:32k.
- R5: Control bit 1 requests a mass erase (`fl_op_o`=3) and is accepted only when the code field in bits 15:8 is 0xAA. Control bit 2 requests a page erase (`fl_op_o`=2) and is accepted only when the code is 0x55. Any other code issues no strobe and sets the fault flag.
- R6: A start request whose key differs from 2 issues no strobe and sets the fault flag.
- R7: Control bit 24 reads 1 while an operation runs. An operation stays busy for exactly N*(div+1) clock cycles from the accepting write, where N is 4 for a program, 20 for a page erase and 40 for a mass erase.
- R8: A start request made while busy sets the fault flag, issues no strobe and does not change the duration of the running operation.
- R9: A control write with more than one of bits 0, 1 and 2 set issues no strobe and sets the fault flag.
- R10: Status bit 0 (done) is set when an operation completes and bit 1 (fault) is set by a refused command. Both are sticky and are cleared by writing 1, while writing 0 leaves them unchanged. Bits 8 and 9 are read/write enables. `irq_o` = (done AND bit 8) OR (fault AND bit 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| fl_strobe_o | output | 1 | One-cycle operation strobe to the flash macro |
| fl_op_o | output | 2 | Operation: 1 program, 2 page erase, 3 mass erase |
| fl_addr_o | output | 32 | Target address |
| fl_data_o | output | 128 | Program data, four words |
| fl_wide_o | output | 1 | 1 for a 128-bit program, 0 for a 32-bit program |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a new start request that lands while an operation is still counting ticks. The request must be refused without shortening or restarting the running countdown. The bench gets there by starting a mass erase and then, while it is still busy, writing a valid program command within the same polling loop that measures the busy time. It then checks that the busy time still equals the mass-erase count and that only one strobe appeared. Busy times are swept over several divider values and all three operation kinds, and each is compared against N*(div+1).

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_PAGE = 2'd2,
    OP_MASS = 2'd3
  } fcs_op_e;

  localparam logic [7:0] OFS_ADDR = 8'h00;
  localparam logic [7:0] OFS_DIV  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h24;
  localparam logic [7:0] OFS_ACC  = 8'h40;
  localparam logic [3:0] DATA_HI  = 4'h3;

  localparam logic [3:0] KEY_OK    = 4'h2;
  localparam logic [7:0] CODE_MASS = 8'hAA;
  localparam logic [7:0] CODE_PAGE = 8'h55;
endpackage

// File: rtl/fcs_tick_gen.sv
module fcs_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // a_r7_phase_restart: a restart with a nonzero divider leaves a gap before the next tick
  a_r7_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int PROG_TICKS = 4,
  parameter int PAGE_TICKS = 20,
  parameter int MASS_TICKS = 40
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  fcs_op_e op_i,
  input  logic    tick_i,
  output logic    busy_o,
  output logic    done_o,
  output logic    strobe_o
);
  localparam int MAX_T = (MASS_TICKS > PAGE_TICKS)
                       ? ((MASS_TICKS > PROG_TICKS) ? MASS_TICKS : PROG_TICKS)
                       : ((PAGE_TICKS > PROG_TICKS) ? PAGE_TICKS : PROG_TICKS);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             busy_q, strobe_q;
  logic [CNT_W-1:0] rem_q, load_val;

  always_comb begin
    unique case (op_i)
      OP_PAGE: load_val = CNT_W'(PAGE_TICKS);
      OP_MASS: load_val = CNT_W'(MASS_TICKS);
      default: load_val = CNT_W'(PROG_TICKS);
    endcase
  end

  assign done_o   = busy_q && tick_i && (rem_q == CNT_W'(1));
  assign busy_o   = busy_q;
  assign strobe_o = strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      rem_q    <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          strobe_q <= 1'b1;
          rem_q    <= load_val;
        end
      end else if (tick_i) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  // a_r3_strobe_in_op: the flash strobe only appears inside a busy window
  a_r3_strobe_in_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> busy_o);
  // a_r7_done_ends_busy: completion is followed by the idle state
  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // a_r8_single_strobe: one strobe per operation
  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int PROG_TICKS = 4,
  parameter int PAGE_TICKS = 20,
  parameter int MASS_TICKS = 40,
  parameter int NWORDS     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [7:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 fl_strobe_o,
  output logic [1:0]           fl_op_o,
  output logic [31:0]          fl_addr_o,
  output logic [NWORDS*32-1:0] fl_data_o,
  output logic                 fl_wide_o,
  output logic                 irq_o
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [31:0]      addr_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      data_q [NWORDS];
  logic             narrow_q;
  logic [7:0]       code_q;
  logic [3:0]       key_q;
  logic [2:0]       pend_q;
  logic             done_q, fault_q, done_ie_q, fault_ie_q;
  fcs_op_e          op_q, op_req;

  logic wr_ctrl, wr_stat, any_start, req_ok, start, refuse;
  logic busy, done_evt, tick;

  assign wr_ctrl   = we_i && addr_i == OFS_CTRL;
  assign wr_stat   = we_i && addr_i == OFS_STAT;
  assign any_start = |wdata_i[2:0];

  always_comb begin
    op_req = OP_NONE;
    req_ok = 1'b0;
    unique case (wdata_i[2:0])
      3'b001: begin op_req = OP_PROG; req_ok = 1'b1; end
      3'b010: begin op_req = OP_MASS; req_ok = wdata_i[15:8] == CODE_MASS; end
      3'b100: begin op_req = OP_PAGE; req_ok = wdata_i[15:8] == CODE_PAGE; end
      default: ;
    endcase
    if (wdata_i[31:28] != KEY_OK) req_ok = 1'b0;
  end

  assign start  = wr_ctrl && any_start && !busy && req_ok;
  assign refuse = wr_ctrl && any_start && !(start);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      div_q      <= '0;
      narrow_q   <= 1'b0;
      code_q     <= '0;
      key_q      <= '0;
      pend_q     <= '0;
      op_q       <= OP_NONE;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      done_ie_q  <= 1'b0;
      fault_ie_q <= 1'b0;
    end else begin
      if (we_i && addr_i == OFS_ADDR) addr_q <= wdata_i;
      if (we_i && addr_i == OFS_DIV)  div_q  <= wdata_i[DIV_W-1:0];
      if (wr_ctrl && !busy) begin
        narrow_q <= wdata_i[4];
        code_q   <= wdata_i[15:8];
        key_q    <= wdata_i[31:28];
      end
      if (start) begin
        pend_q <= wdata_i[2:0];
        op_q   <= op_req;
      end else if (done_evt) begin
        pend_q <= '0;
      end
      if (wr_stat) begin
        done_ie_q  <= wdata_i[8];
        fault_ie_q <= wdata_i[9];
      end
      // a new event wins over a same-cycle clear
      done_q  <= done_evt || (done_q  && !(wr_stat && wdata_i[0]));
      fault_q <= refuse   || (fault_q && !(wr_stat && wdata_i[1]));
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q[g] <= '0;
      else if (we_i && addr_i[7:4] == DATA_HI && addr_i[1:0] == 2'b00
               && addr_i[3:2] == 2'(g))
        data_q[g] <= wdata_i;
    end
    assign fl_data_o[g*32 +: 32] = data_q[g];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_ADDR: rdata_o = addr_q;
      OFS_DIV:  rdata_o[DIV_W-1:0] = div_q;
      OFS_CTRL: rdata_o = {key_q, 3'b000, busy, 8'h00, code_q, 3'b000, narrow_q, 1'b0, pend_q};
      OFS_STAT: rdata_o = {22'h0, fault_ie_q, done_ie_q, 6'h0, fault_q, done_q};
      default:
        if (addr_i[7:4] == DATA_HI && addr_i[1:0] == 2'b00 && 32'(addr_i[3:2]) < NWORDS)
          rdata_o = data_q[IDX_W'(addr_i[3:2])];
    endcase
  end

  fcs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_q),
    .restart_i (start),
    .tick_o    (tick)
  );

  fcs_seq #(
    .PROG_TICKS (PROG_TICKS),
    .PAGE_TICKS (PAGE_TICKS),
    .MASS_TICKS (MASS_TICKS)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .op_i     (op_req),
    .tick_i   (tick),
    .busy_o   (busy),
    .done_o   (done_evt),
    .strobe_o (fl_strobe_o)
  );

  assign fl_op_o   = op_q;
  assign fl_addr_o = addr_q;
  assign fl_wide_o = !narrow_q;
  assign irq_o     = (done_q && done_ie_q) || (fault_q && fault_ie_q);

  // a_r6_key_on_strobe: no operation reaches the flash without the unlock key
  a_r6_key_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_strobe_o |-> key_q == KEY_OK);
  // a_r9_one_pending: exactly one start bit is held during an operation
  a_r9_one_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $countones(pend_q) == 1);
  // a_r10_fault_source: the fault flag only rises after a control write
  a_r10_fault_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(we_i && addr_i == OFS_CTRL));
  // a_r5_erase_code: an erase strobe implies the matching code is held
  a_r5_erase_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_strobe_o && fl_op_o == OP_MASS) |-> code_q == CODE_MASS);
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int PT = 4, GT = 20, MT = 40;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we_i = 1'b0;
  logic [7:0]   addr_i = 8'h0;
  logic [31:0]  wdata_i = 32'h0;
  logic [31:0]  rdata_o;
  logic         fl_strobe_o;
  logic [1:0]   fl_op_o;
  logic [31:0]  fl_addr_o;
  logic [127:0] fl_data_o;
  logic         fl_wide_o;
  logic         irq_o;

  always #2 clk_i = ~clk_i;

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .fl_strobe_o, .fl_op_o, .fl_addr_o, .fl_data_o, .fl_wide_o, .irq_o
  );

  int n_chk = 0, n_fail = 0, n_strobe = 0;
  logic [1:0]  last_op;
  logic [31:0] last_addr;
  logic [31:0] mem [8];
  bit finished = 0;

  // behavioural flash array: 8 words, erase sets ones, program ANDs
  always @(posedge clk_i) begin
    if (fl_strobe_o) begin
      n_strobe++;
      last_op   = fl_op_o;
      last_addr = fl_addr_o;
      case (fl_op_o)
        2'd1: if (fl_wide_o) begin
                for (int k = 0; k < 4; k++)
                  mem[{fl_addr_o[4], 2'(k)}] &= fl_data_o[k*32 +: 32];
              end else mem[fl_addr_o[4:2]] &= fl_data_o[31:0];
        2'd2, 2'd3: for (int k = 0; k < 8; k++) mem[k] = 32'hFFFF_FFFF;
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  function automatic logic [31:0] ctl(input logic [3:0] key, input logic [7:0] code,
                                      input logic narrow, input logic [2:0] st);
    return {key, 12'h0, code, 3'b000, narrow, 1'b0, st};
  endfunction

  // runs a command and returns busy cycles and the start bits seen first
  task automatic run(input logic [31:0] c, output int cyc, output logic [2:0] st0);
    logic [31:0] v;
    wr(8'h08, c);
    cyc = 0;
    rd(8'h08, v);
    st0 = v[2:0];
    while (v[24] && cyc < 1000) begin
      cyc++;
      @(negedge clk_i);
      rd(8'h08, v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, s0;
    logic [2:0] st;
    int nt [3];
    logic [2:0] sbits [3];
    logic [7:0] codes [3];
    logic [1:0] opc [3];
    nt = '{PT, GT, MT};
    sbits = '{3'b001, 3'b100, 3'b010};
    codes = '{8'h00, 8'h55, 8'hAA};
    opc = '{2'd1, 2'd2, 2'd3};
    for (int k = 0; k < 8; k++) mem[k] = 32'h0;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    foreach (codes[i]) begin end
    rd(8'h00, v); check("R1 addr", v, 0);
    rd(8'h08, v); check("R1 ctrl", v, 0);
    rd(8'h24, v); check("R1 stat", v, 0);
    check("R1 irq", {31'h0, irq_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 strobes", n_strobe, 0);

    // R2 register map
    wr(8'h00, 32'h0000_0010);
    wr(8'h04, 32'h0000_0003);
    for (int k = 0; k < 4; k++) wr(8'h30 + 8'(4*k), 32'hC0DE_0000 + 32'(k * 32'h1111));
    rd(8'h00, v); check("R2 addr", v, 32'h10);
    rd(8'h04, v); check("R2 div", v, 3);
    for (int k = 0; k < 4; k++) begin
      rd(8'h30 + 8'(4*k), v); check("R2 data", v, 32'hC0DE_0000 + 32'(k * 32'h1111));
    end
    wr(8'h40, 32'h3A7F_5CA3);
    rd(8'h40, v); check("R2 access reads zero", v, 0);

    // R7 timing sweep over divider and operation; R3/R5 op codes
    for (int d = 0; d < 4; d++) begin
      wr(8'h04, 32'(d));
      for (int o = 0; o < 3; o++) begin
        s0 = n_strobe;
        run(ctl(4'h2, codes[o], 1'b0, sbits[o]), cyc, st);
        check("R7 busy cycles", cyc, nt[o] * (d + 1));
        check("R3 start bit while busy", st, sbits[o]);
        check("R3 one strobe", n_strobe - s0, 1);
        check("R5 op code", last_op, opc[o]);
        rd(8'h08, v); check("R3 start bits clear", v[2:0], 0);
        rd(8'h24, v); check("R10 done set", v[1:0], 2'b01);
        wr(8'h24, 32'h1);
        rd(8'h24, v); check("R10 done cleared", v[1:0], 2'b00);
      end
    end

    // R4 width: mass erase, wide program at 0x10, narrow at 0x08
    wr(8'h04, 32'h0);
    run(ctl(4'h2, 8'hAA, 1'b0, 3'b010), cyc, st);
    wr(8'h00, 32'h10);
    run(ctl(4'h2, 8'h00, 1'b0, 3'b001), cyc, st);
    check("R3 addr", last_addr, 32'h10);
    for (int k = 0; k < 4; k++)
      check("R4 wide word", mem[4 + k], 32'hC0DE_0000 + 32'(k * 32'h1111));
    check("R4 untouched", mem[2], 32'hFFFF_FFFF);
    wr(8'h00, 32'h08);
    run(ctl(4'h2, 8'h00, 1'b1, 3'b001), cyc, st);
    check("R4 narrow word", mem[2], 32'hC0DE_0000);
    check("R4 narrow neighbour", mem[3], 32'hFFFF_FFFF);
    check("R4 wide flag low", {31'h0, fl_wide_o}, 0);
    wr(8'h24, 32'h1);

    // R6 wrong keys
    for (int key = 0; key < 16; key++) begin
      if (key == 2) continue;
      s0 = n_strobe;
      wr(8'h08, ctl(4'(key), 8'h00, 1'b0, 3'b001));
      @(negedge clk_i);
      check("R6 no strobe", n_strobe - s0, 0);
      rd(8'h24, v); check("R6 fault", v[1:0], 2'b10);
      wr(8'h24, 32'h2);
    end

    // R5 bad erase codes
    for (int c = 0; c < 256; c += 17) begin
      s0 = n_strobe;
      wr(8'h08, ctl(4'h2, 8'(c), 1'b0, 3'b010));
      @(negedge clk_i);
      rd(8'h24, v);
      check("R5 mass code", {30'h0, v[1], 1'(n_strobe - s0)},
            (c == 8'hAA) ? 32'h1 : 32'h2);
      if (c == 8'hAA) while (1) begin rd(8'h08, v); if (!v[24]) break; @(negedge clk_i); end
      wr(8'h24, 32'h3);
    end
    s0 = n_strobe;
    wr(8'h08, ctl(4'h2, 8'hAA, 1'b0, 3'b100));
    @(negedge clk_i);
    rd(8'h24, v); check("R5 page needs 0x55", v[1:0], 2'b10);
    check("R5 page no strobe", n_strobe - s0, 0);
    wr(8'h24, 32'h2);

    // R9 several start bits
    for (int b = 3; b < 8; b++) begin
      if (b == 4) continue;
      s0 = n_strobe;
      wr(8'h08, ctl(4'h2, 8'h55, 1'b0, 3'(b)));
      @(negedge clk_i);
      check("R9 no strobe", n_strobe - s0, 0);
      rd(8'h24, v); check("R9 fault", v[1:0], 2'b10);
      wr(8'h24, 32'h2);
    end

    // R8 start while busy
    wr(8'h04, 32'h1);
    s0 = n_strobe;
    wr(8'h08, ctl(4'h2, 8'hAA, 1'b0, 3'b010));
    cyc = 0;
    rd(8'h08, v);
    while (v[24] && cyc < 1000) begin
      cyc++;
      if (cyc == 5) begin wdata_i = ctl(4'h2, 8'h00, 1'b0, 3'b001); we_i = 1'b1; end
      else we_i = 1'b0;
      @(negedge clk_i);
      rd(8'h08, v);
    end
    we_i = 1'b0;
    check("R8 duration unchanged", cyc, MT * 2);
    check("R8 single strobe", n_strobe - s0, 1);
    check("R8 op kept", last_op, 2'd3);
    rd(8'h24, v); check("R8 fault and done", v[1:0], 2'b11);

    // R10 W1C and interrupt masking
    wr(8'h24, 32'h0000_0000);
    rd(8'h24, v); check("R10 write zero keeps flags", v, 32'h3);
    check("R10 irq masked", {31'h0, irq_o}, 0);
    wr(8'h24, 32'h0000_0100);
    check("R10 irq done", {31'h0, irq_o}, 1);
    wr(8'h24, 32'h0000_0201);
    rd(8'h24, v); check("R10 clear done", v, 32'h0000_0202);
    check("R10 irq fault", {31'h0, irq_o}, 1);
    wr(8'h24, 32'h0000_0202);
    check("R10 irq off", {31'h0, irq_o}, 0);
    rd(8'h24, v); check("R10 enables", v, 32'h0000_0200);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule